// File: doc/BRIEF.md
# Camera Receiver Control and Interrupt Register Block

This block is the host-visible register file of a serial camera receiver. A simple 32-bit register port (write strobe, address, write data, combinational read data) lets software switch the receiver core on, request a soft reset, choose how many data lanes are active, read core status and service interrupts. The lane front end, packet decoder and pixel path sit elsewhere; they reach this block only as single-cycle event pulses, a packet-received pulse and three level status signals.

Internally a small sequencer reports a reset-or-disable in progress for a fixed, bounded number of cycles. A saturating counter tallies received packets. An interrupt unit latches events into a write-one-to-clear status register, masks them with an enable register and a global enable, and drives one interrupt line. Software typically enables the core, pulses soft reset, waits for the in-progress flag to drop, programs the enables and then services interrupts by writing back the bits it has read.

Top module: `camrx_csr`

## Requirements
- R1: After reset every writable register reads zero except the active-lane field, which reads the maximum lane count minus one; the interrupt line is low.
- R2: Offset 0x00 holds core enable in bit 0 and soft-reset request in bit 1; both read back, drive `core_en_o` and `soft_rst_o`, and bits 31:2 read zero.
- R3: Offset 0x04 reads the maximum lane count minus one in bits [4:3] (writes there are ignored) and a writable active-lane code in bits [1:0], driven on `act_lanes_o`.
- R4: A write that raises the soft-reset bit, or clears the enable bit while it was set, makes bit 0 of offset 0x10 read 1 from the next cycle for exactly RST_CYCLES cycles (fewer than 100), after which it reads 0 even while soft reset stays set.
- R5: Bits 1, 2 and 3 of offset 0x10 follow the line-buffer-full, short-packet-FIFO-not-empty and short-packet-FIFO-full inputs; bits 15:4 read zero.
- R6: Bits [31:16] of offset 0x10 count `pkt_rcvd_i` cycles, saturate at 0xFFFF, and are held at zero while the soft-reset bit is set.
- R7: Offset 0x24 latches each event pulse on a bit of mask 0xC07E3FFF whether or not it is enabled; bits outside the mask read zero; the register is held at zero while soft reset is set.
- R8: Writing 0x24 clears the bits written as 1 and leaves the others; an event arriving in the cycle of that write keeps its bit set.
- R9: Offset 0x28 stores the enable for each implemented status bit except bit 30, which, like every unimplemented bit, reads zero.
- R10: Offset 0x20 bit 0 is the global interrupt enable; other bits read zero.
- R11: `irq_o` is high exactly when the global enable is set and some status bit is set with its enable set.
- R12: Writes to offset 0x10 and to unmapped offsets change nothing, and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| evt_i | input | 32 | Event pulses, one per status bit position |
| pkt_rcvd_i | input | 1 | Packet received pulse |
| lbuf_full_i | input | 1 | Line buffer full level |
| spf_nempty_i | input | 1 | Short-packet FIFO not empty level |
| spf_full_i | input | 1 | Short-packet FIFO full level |
| core_en_o | output | 1 | Core enable |
| soft_rst_o | output | 1 | Soft reset request |
| act_lanes_o | output | 2 | Active lane code |
| irq_o | output | 1 | Interrupt line |

## Verification
The properties assume that event and packet pulses are synchronous to the clock and that the host issues at most one write per cycle with a stable address. They also assume that RST_CYCLES stays well under 100, since the in-progress window is bounded against that fixed limit. The bench changes inputs only on the falling edge and drives single-cycle pulses or held levels, so every edge sees one settled value. The same-cycle event-and-clear case is driven on purpose, because the set-wins rule is the one ordering the interrupt unit must resolve.

// File: rtl/camrx_csr_pkg.sv
package camrx_csr_pkg;

    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_LANE = 8'h04;
    localparam logic [7:0] A_STAT = 8'h10;
    localparam logic [7:0] A_GIE  = 8'h20;
    localparam logic [7:0] A_ISR  = 8'h24;
    localparam logic [7:0] A_IER  = 8'h28;

    localparam int          SUMMARY_BIT = 30;
    localparam logic [31:0] ISR_MASK    = 32'hC07E_3FFF;
    localparam logic [31:0] IER_MASK    = ISR_MASK & ~(32'h1 << SUMMARY_BIT);

    localparam int PKT_W = 16;

    typedef struct packed {
        logic       en;
        logic       srst;
        logic [1:0] act;
    } ctrl_st_t;

    typedef struct packed {
        logic [31:0] isr;
        logic [31:0] ier;
        logic        gie;
    } irq_st_t;

endpackage

// File: rtl/camrx_rst_seq.sv
module camrx_rst_seq #(
    parameter int RST_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(RST_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(RST_CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/camrx_sat_cnt.sv
module camrx_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i && cnt_q != TOP) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/camrx_irq_unit.sv
module camrx_irq_unit
    import camrx_csr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hold_i,
    input  logic [31:0] evt_i,
    input  logic        isr_we_i,
    input  logic        ier_we_i,
    input  logic        gie_we_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] isr_o,
    output logic [31:0] ier_o,
    output logic        gie_o,
    output logic        irq_o
);
    irq_st_t st_d, st_q;
    logic    hit;

    always_comb begin
        st_d = st_q;
        if (isr_we_i) begin
            st_d.isr = st_q.isr & ~wdata_i;
        end
        st_d.isr = (st_d.isr | evt_i) & ISR_MASK;
        if (hold_i) begin
            st_d.isr = '0;
        end
        if (ier_we_i) begin
            st_d.ier = wdata_i & IER_MASK;
        end
        if (gie_we_i) begin
            st_d.gie = wdata_i[0];
        end
        hit = |(st_q.isr & st_q.ier);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign isr_o = st_q.isr;
    assign ier_o = st_q.ier;
    assign gie_o = st_q.gie;
    assign irq_o = st_q.gie & hit;
endmodule

// File: rtl/camrx_csr.sv
module camrx_csr
    import camrx_csr_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int MAX_LANES  = 4,
    parameter int RST_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       evt_i,
    input  logic              pkt_rcvd_i,
    input  logic              lbuf_full_i,
    input  logic              spf_nempty_i,
    input  logic              spf_full_i,
    output logic              core_en_o,
    output logic              soft_rst_o,
    output logic [1:0]        act_lanes_o,
    output logic              irq_o
);
    localparam logic [1:0]        MAXL     = 2'(MAX_LANES - 1);
    localparam logic [ADDR_W-1:0] AD_CTRL  = ADDR_W'(A_CTRL);
    localparam logic [ADDR_W-1:0] AD_LANE  = ADDR_W'(A_LANE);
    localparam logic [ADDR_W-1:0] AD_STAT  = ADDR_W'(A_STAT);
    localparam logic [ADDR_W-1:0] AD_GIE   = ADDR_W'(A_GIE);
    localparam logic [ADDR_W-1:0] AD_ISR   = ADDR_W'(A_ISR);
    localparam logic [ADDR_W-1:0] AD_IER   = ADDR_W'(A_IER);

    ctrl_st_t          c_d, c_q;
    logic              seq_start;
    logic              rip_w;
    logic [PKT_W-1:0]  pkt_w;
    logic [31:0]       isr_w, ier_w;
    logic              gie_w;
    logic              wr_isr, wr_ier, wr_gie;

    always_comb begin
        c_d       = c_q;
        seq_start = 1'b0;
        if (bus_we && bus_addr == AD_CTRL) begin
            c_d.en    = bus_wdata[0];
            c_d.srst  = bus_wdata[1];
            seq_start = (bus_wdata[1] && !c_q.srst) || (!bus_wdata[0] && c_q.en);
        end
        if (bus_we && bus_addr == AD_LANE) begin
            c_d.act = bus_wdata[1:0];
        end
        wr_isr = bus_we && bus_addr == AD_ISR;
        wr_ier = bus_we && bus_addr == AD_IER;
        wr_gie = bus_we && bus_addr == AD_GIE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{en: 1'b0, srst: 1'b0, act: MAXL};
        else        c_q <= c_d;
    end

    camrx_rst_seq #(.RST_CYCLES(RST_CYCLES)) rseq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (seq_start),
        .busy_o  (rip_w)
    );

    camrx_sat_cnt #(.W(PKT_W)) pcnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (c_q.srst),
        .inc_i (pkt_rcvd_i),
        .cnt_o (pkt_w)
    );

    camrx_irq_unit irq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_i   (c_q.srst),
        .evt_i    (evt_i),
        .isr_we_i (wr_isr),
        .ier_we_i (wr_ier),
        .gie_we_i (wr_gie),
        .wdata_i  (bus_wdata),
        .isr_o    (isr_w),
        .ier_o    (ier_w),
        .gie_o    (gie_w),
        .irq_o    (irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            AD_CTRL: bus_rdata = {30'b0, c_q.srst, c_q.en};
            AD_LANE: bus_rdata = {27'b0, MAXL, 1'b0, c_q.act};
            AD_STAT: bus_rdata = {pkt_w, 12'b0, spf_full_i, spf_nempty_i, lbuf_full_i, rip_w};
            AD_GIE:  bus_rdata = {31'b0, gie_w};
            AD_ISR:  bus_rdata = isr_w;
            AD_IER:  bus_rdata = ier_w;
            default: bus_rdata = '0;
        endcase
    end

    assign core_en_o   = c_q.en;
    assign soft_rst_o  = c_q.srst;
    assign act_lanes_o = c_q.act;
endmodule

// File: rtl/camrx_csr_chk.sv
module camrx_csr_chk
    import camrx_csr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic [31:0]       evt_i,
    input logic [31:0]       isr,
    input logic [31:0]       ier,
    input logic              gie,
    input logic              srst,
    input logic              rip,
    input logic [PKT_W-1:0]  pkt,
    input logic              irq_o
);
    logic [7:0] rip_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             rip_run <= '0;
        else if (!rip)          rip_run <= '0;
        else if (rip_run != '1) rip_run <= rip_run + 1'b1;
    end

    // R4: the in-progress flag never stays up for 100 cycles
    a_r4_rip_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        rip_run < 8'd100);

    // R6: a saturated packet count stays saturated outside soft reset
    a_r6_pkt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt == '1 && !srst) |=> pkt == '1);

    // R7: any masked event outside soft reset is latched on the next edge
    a_r7_evt_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst && (evt_i & ISR_MASK) != 0)
        |=> ((isr & $past(evt_i & ISR_MASK)) == $past(evt_i & ISR_MASK)));

    // R7: unimplemented status bits read zero at the port
    a_r7_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(A_ISR)) |-> ((bus_rdata & ~ISR_MASK) == 32'h0));

    // R9: the summary bit can never be enabled
    a_r9_no_summary_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !ier[SUMMARY_BIT]);

    // R11: no interrupt without the global enable
    a_r11_irq_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> !irq_o);
endmodule

bind camrx_csr camrx_csr_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .evt_i     (evt_i),
    .isr       (isr_w),
    .ier       (ier_w),
    .gie       (gie_w),
    .srst      (soft_rst_o),
    .rip       (rip_w),
    .pkt       (pkt_w),
    .irq_o     (irq_o)
);

// File: tb/camrx_csr_tb.sv
module camrx_csr_tb_top;
    localparam int RSTC = 20;
    localparam int NV   = 26;
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_EV = 2'd2, OP_IQ = 2'd3;

    // {op, addr, data, expected}
    localparam logic [73:0] VEC [NV] = '{
        {OP_RD, 8'h00, 32'h0,        32'h0},          // R1
        {OP_RD, 8'h04, 32'h0,        32'h0000_001B},  // R1
        {OP_IQ, 8'h00, 32'h0,        32'h0},          // R1
        {OP_WR, 8'h04, 32'h0000_0019, 32'h0},
        {OP_RD, 8'h04, 32'h0,        32'h0000_0019},  // R3
        {OP_WR, 8'h04, 32'h0000_0002, 32'h0},
        {OP_RD, 8'h04, 32'h0,        32'h0000_001A},  // R3
        {OP_WR, 8'h28, 32'hFFFF_FFFF, 32'h0},
        {OP_RD, 8'h28, 32'h0,        32'h807E_3FFF},  // R9
        {OP_EV, 8'h00, 32'hFFFF_FFFF, 32'h0},
        {OP_RD, 8'h24, 32'h0,        32'hC07E_3FFF},  // R7
        {OP_IQ, 8'h00, 32'h0,        32'h0},          // R11 gie off
        {OP_WR, 8'h20, 32'hFFFF_FFFF, 32'h0},
        {OP_RD, 8'h20, 32'h0,        32'h1},          // R10
        {OP_IQ, 8'h00, 32'h0,        32'h1},          // R11
        {OP_WR, 8'h24, 32'h807E_3FFF, 32'h0},
        {OP_RD, 8'h24, 32'h0,        32'h4000_0000},  // R8
        {OP_IQ, 8'h00, 32'h0,        32'h0},          // R11 bit 30 not enabled
        {OP_WR, 8'h24, 32'h4000_0000, 32'h0},
        {OP_WR, 8'h28, 32'h0000_0200, 32'h0},
        {OP_EV, 8'h00, 32'h0000_0100, 32'h0},
        {OP_RD, 8'h24, 32'h0,        32'h0000_0100},  // R7 latched while disabled
        {OP_IQ, 8'h00, 32'h0,        32'h0},          // R11
        {OP_EV, 8'h00, 32'h0000_0200, 32'h0},
        {OP_IQ, 8'h00, 32'h0,        32'h1},          // R11
        {OP_RD, 8'h80, 32'h0,        32'h0}           // R12
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] evt_i = '0;
    logic        pkt_rcvd_i = 1'b0;
    logic        lbuf_full_i = 1'b0;
    logic        spf_nempty_i = 1'b0;
    logic        spf_full_i = 1'b0;
    logic        core_en_o, soft_rst_o, irq_o;
    logic [1:0]  act_lanes_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    camrx_csr #(.ADDR_W(8), .MAX_LANES(4), .RST_CYCLES(RSTC)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i),
        .pkt_rcvd_i(pkt_rcvd_i), .lbuf_full_i(lbuf_full_i),
        .spf_nempty_i(spf_nempty_i), .spf_full_i(spf_full_i),
        .core_en_o(core_en_o), .soft_rst_o(soft_rst_o),
        .act_lanes_o(act_lanes_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(input logic [31:0] v);
        evt_i = v;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        logic [31:0] r;
        int busy;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [7:0]  a;
            logic [31:0] d, e;
            {op, a, d, e} = VEC[i];
            case (op)
                OP_WR: wr(a, d);
                OP_RD: begin rd(a, r); check($sformatf("R1/R3/R7/R8/R9/R10/R12 vec%0d", i), r, e); end
                OP_EV: pulse(d);
                default: check($sformatf("R11 vec%0d irq", i), {31'b0, irq_o}, e);
            endcase
        end

        // R12: writes to the status offset are ignored
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, r); check("R12 status write ignored", r, 32'h0);
        wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h28, r); check("R12 unmapped write ignored", r, 32'h0000_0200);

        // R8: set wins over a same-cycle clear
        pulse(32'h1);
        evt_i = 32'h1;
        wr(8'h24, 32'h1);
        evt_i = '0;
        rd(8'h24, r); check("R8 set wins", r, 32'h0000_0301);
        wr(8'h24, 32'h0000_0001);
        rd(8'h24, r); check("R8 clear leaves others", r, 32'h0000_0300);

        // R5: level inputs
        lbuf_full_i = 1'b1;
        rd(8'h10, r); check("R5 line buffer full", r, 32'h2);
        lbuf_full_i = 1'b0; spf_nempty_i = 1'b1;
        rd(8'h10, r); check("R5 fifo not empty", r, 32'h4);
        spf_nempty_i = 1'b0; spf_full_i = 1'b1;
        rd(8'h10, r); check("R5 fifo full", r, 32'h8);
        spf_full_i = 1'b0;

        // R6: packet count
        pkt_rcvd_i = 1'b1;
        repeat (5) @(negedge clk);
        pkt_rcvd_i = 1'b0;
        rd(8'h10, r); check("R6 count five", r, 32'h0005_0000);
        pkt_rcvd_i = 1'b1;
        repeat (70000) @(negedge clk);
        pkt_rcvd_i = 1'b0;
        rd(8'h10, r); check("R6 saturated", r, 32'hFFFF_0000);

        // R2: control register
        wr(8'h00, 32'hFFFF_FFFD);
        rd(8'h00, r); check("R2 enable readback", r, 32'h1);
        check("R2 core_en_o", {31'b0, core_en_o}, 32'h1);

        // R4: soft reset raises in-progress for RSTC cycles
        wr(8'h00, 32'h3);
        check("R2 soft_rst_o", {31'b0, soft_rst_o}, 32'h1);
        busy = 0;
        for (int k = 0; k < 200; k++) begin
            rd(8'h10, r);
            if (!r[0]) break;
            busy++;
            @(negedge clk);
        end
        check("R4 in-progress length", busy, RSTC);
        rd(8'h00, r); check("R4 soft reset still held", r, 32'h3);
        rd(8'h10, r); check("R6 count held zero in soft reset", r, 32'h0);
        rd(8'h24, r); check("R7 status held zero in soft reset", r, 32'h0);
        pulse(32'h0000_0200);
        pkt_rcvd_i = 1'b1; @(negedge clk); pkt_rcvd_i = 1'b0;
        rd(8'h24, r); check("R7 event ignored in soft reset", r, 32'h0);
        rd(8'h10, r); check("R6 packet ignored in soft reset", r, 32'h0);

        // R4: disable also reports in-progress
        wr(8'h00, 32'h1);
        pkt_rcvd_i = 1'b1; @(negedge clk); pkt_rcvd_i = 1'b0;
        rd(8'h10, r); check("R6 count resumes", r[31:16], 32'h1);
        wr(8'h00, 32'h0);
        rd(8'h10, r); check("R4 disable in progress", r & 32'h1, 32'h1);
        check("R3 act_lanes_o", {30'b0, act_lanes_o}, 32'h2);

        done = 1'b1;
        finish_run();
    end
endmodule